// File: doc/BRIEF.md
# Dual-Clock Event Buffer with Hysteretic Halt

This block sits between per-channel sample gating and the serial readout of one eight-channel section. Every channel has its own buffer. Gated samples are written into it on the sample clock. A readout engine on a faster, unrelated clock drains the eight buffers through a single output port. It serves the channels that hold data in rotating order and passes over the empty ones.

Acquisition is armed by a rising edge of an acquisition-enable input, as seen in the sample-clock domain. Once armed, the block keeps accepting samples while that input stays high. When any buffer reaches its capacity, a section-wide halt flag goes up and every channel stops storing. The flag drops only after every buffer has drained to a quarter of its capacity or less. This hysteresis stops acquisition from toggling on and off around the full level.

Buffer depth is a power of two set by `AW`. A depth of 4096 holds a complete 3K-sample event. The default is kept small so the project elaborates quickly. Pointers cross between the clocks as Gray codes through two-flop synchronizers.

Top module: `evbuf_section`

## Requirements
- R1: After reset, `wr_halt` and `rd_valid` are 0, every buffer is empty, and holding `rd_en` high produces no output words.
- R2: Words from one channel leave in the order they were accepted, with their 12-bit value unchanged.
- R3: A buffer never accepts a word while it holds 2^AW words, and its occupancy never exceeds 2^AW.
- R4: One sample-clock cycle after any buffer holds 2^AW words, `wr_halt` is 1. While it is 1, writes to every channel are discarded.
- R5: `wr_halt` returns to 0 only once every buffer, as seen from the write side, holds at most 2^AW/4 words. After that, writes are accepted again.
- R6: Writes are accepted only after a 0-to-1 transition of `wr_acq_en` has been seen on `wr_clk`, and only while it stays 1. A level that is already high when reset is released does not arm acquisition.
- R7: A word is removed only in a `rd_clk` cycle with `rd_en` high and some buffer non-empty. `rd_valid` is 1 in the following cycle exactly when such a removal took place.
- R8: After reset the search starts at channel 0. Each removal goes to the first non-empty channel after the last one served, in ascending order with wrap-around, and empty channels are skipped.
- R9: `rd_chan` gives the 3-bit number (0 to 7) of the channel that `rd_data` came from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| wr_acq_en | input | 1 | Acquisition enable; a rising edge arms acquisition |
| wr_valid | input | 8 | Per-channel write strobe; bit i is channel i |
| wr_data | input | 8*DW | Samples; channel i occupies bits [i*DW +: DW] |
| wr_halt | output | 1 | Hysteretic halt flag (sample-clock domain) |
| rd_clk | input | 1 | Readout clock |
| rd_en | input | 1 | Readout enable |
| rd_valid | output | 1 | Output word present |
| rd_chan | output | 3 | Source channel of the output word |
| rd_data | output | DW | Output sample |

## Verification
A write becomes visible to the reader two to three `rd_clk` cycles after its `wr_clk` edge. A removal in cycle n shows on `rd_valid`, `rd_chan` and `rd_data` in cycle n+1. So the bench lets several read cycles pass after each batch of writes before it enables readout. It then keeps collecting output for four read cycles after dropping `rd_en`. The halt flag rises one write cycle after the filling write. It clears about three write cycles after the read that takes occupancy to the quarter level, because two synchronizer stages sit on that path. The bench therefore samples the flag three to six write cycles after each stimulus. The armed state takes three write cycles to follow `wr_acq_en`, and the bench waits four before it writes.

// File: rtl/evbuf_pkg.sv
package evbuf_pkg;
  localparam int NCH = 8;
  localparam int CHW = $clog2(NCH);
endpackage

// File: rtl/evbuf_rst_sync.sv
module evbuf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/evbuf_sync2.sv
module evbuf_sync2 #(
  parameter int W = 1,
  parameter bit RV = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= {W{RV}};
      s2_q <= {W{RV}};
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/evbuf_chan_fifo.sv
module evbuf_chan_fifo #(
  parameter int DW = 12,
  parameter int AW = 8
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_push,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  output logic [AW:0]   wr_occ,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty
);
  localparam int DEPTH = 1 << AW;

  function automatic logic [AW:0] to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] from_gray(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write side
  logic [AW:0] wbin_q, wbin_d, wgray_q, wgray_d, rgray_ws;
  logic [AW:0] rbin_q, rbin_d, rgray_q, rgray_d, wgray_rs;

  always_comb begin
    wbin_d  = wbin_q + (wr_push ? 1'b1 : 1'b0);
    wgray_d = to_gray(wbin_d);
  end

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  always_ff @(posedge wr_clk) begin
    if (wr_push) mem[wbin_q[AW-1:0]] <= wr_data;
  end

  evbuf_sync2 #(.W(AW+1), .RV(1'b0)) u_rptr_sync (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray_q), .q(rgray_ws)
  );

  assign wr_full = (wgray_q == {~rgray_ws[AW:AW-1], rgray_ws[AW-2:0]});
  assign wr_occ  = wbin_q - from_gray(rgray_ws);

  // read side
  always_comb begin
    rbin_d  = rbin_q + (rd_pop ? 1'b1 : 1'b0);
    rgray_d = to_gray(rbin_d);
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
    end
  end

  evbuf_sync2 #(.W(AW+1), .RV(1'b0)) u_wptr_sync (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray_q), .q(wgray_rs)
  );

  assign rd_empty = (rgray_q == wgray_rs);
  assign rd_data  = mem[rbin_q[AW-1:0]];

  // R3: the top must never push into a full buffer
  a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_push |-> !wr_full);
  // R3: occupancy bounded by capacity
  a_r3_occ_bound: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_occ <= (AW+1)'(DEPTH));
  // R7: the arbiter never removes from an empty buffer
  a_r7_no_pop_empty: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_pop |-> !rd_empty);
endmodule

// File: rtl/evbuf_rr_arb.sv
module evbuf_rr_arb #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  logic [IW-1:0] last_q, last_d;

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = last_q;
    for (int k = 1; k <= N; k++) begin
      if (!gnt_any && req[(int'(last_q) + k) % N]) begin
        gnt_any = 1'b1;
        gnt_idx = IW'((int'(last_q) + k) % N);
      end
    end
    gnt    = gnt_any ? (N'(1) << gnt_idx) : '0;
    last_d = (adv && gnt_any) ? gnt_idx : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else        last_q <= last_d;
  end

  // R8: a grant always lands on a requesting channel
  a_r8_grant_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_any |-> req[gnt_idx]);
  // R8: the served channel becomes the search origin
  a_r8_origin_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && gnt_any) |=> (last_q == $past(gnt_idx)));
endmodule

// File: rtl/evbuf_section.sv
module evbuf_section
  import evbuf_pkg::*;
#(
  parameter int DW = 12,
  parameter int AW = 8
) (
  input  logic              wr_clk,
  input  logic              rst_n,
  input  logic              wr_acq_en,
  input  logic [NCH-1:0]    wr_valid,
  input  logic [NCH*DW-1:0] wr_data,
  output logic              wr_halt,
  input  logic              rd_clk,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [CHW-1:0]    rd_chan,
  output logic [DW-1:0]     rd_data
);
  localparam int DEPTH   = 1 << AW;
  localparam int LOW_LVL = DEPTH / 4;

  logic wr_rst_n, rd_rst_n;

  evbuf_rst_sync u_wrst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wr_rst_n));
  evbuf_rst_sync u_rrst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rd_rst_n));

  // acquisition arming (write domain); reset value 1 hides a level held at reset
  logic ae_s, ae_prev_q, run_q, run_d;

  evbuf_sync2 #(.W(1), .RV(1'b1)) u_ae_sync (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(wr_acq_en), .q(ae_s)
  );

  always_comb begin
    run_d = ae_s && (run_q || !ae_prev_q);
  end

  // hysteretic halt
  logic [NCH-1:0] full_v, empty_v, push_v, pop_v, low_v;
  logic [AW:0]    occ   [NCH];
  logic [DW-1:0]  rdat  [NCH];
  logic           any_full, all_low, halt_q, halt_d;

  always_comb begin
    any_full = |full_v;
    all_low  = &low_v;
    if (any_full)     halt_d = 1'b1;
    else if (all_low) halt_d = 1'b0;
    else              halt_d = halt_q;
  end

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      ae_prev_q <= 1'b1;
      run_q     <= 1'b0;
      halt_q    <= 1'b0;
    end else begin
      ae_prev_q <= ae_s;
      run_q     <= run_d;
      halt_q    <= halt_d;
    end
  end

  assign wr_halt = halt_q;

  // per-channel buffers
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign push_v[c] = wr_valid[c] && run_q && ae_s && !halt_q && !any_full;
    assign low_v[c]  = (occ[c] <= (AW+1)'(LOW_LVL));

    evbuf_chan_fifo #(.DW(DW), .AW(AW)) u_fifo (
      .wr_clk   (wr_clk),
      .wr_rst_n (wr_rst_n),
      .wr_push  (push_v[c]),
      .wr_data  (wr_data[c*DW +: DW]),
      .wr_full  (full_v[c]),
      .wr_occ   (occ[c]),
      .rd_clk   (rd_clk),
      .rd_rst_n (rd_rst_n),
      .rd_pop   (pop_v[c]),
      .rd_data  (rdat[c]),
      .rd_empty (empty_v[c])
    );
  end

  // readout multiplexer
  logic [NCH-1:0] gnt;
  logic [CHW-1:0] gnt_idx;
  logic           gnt_any;

  evbuf_rr_arb #(.N(NCH), .IW(CHW)) u_arb (
    .clk     (rd_clk),
    .rst_n   (rd_rst_n),
    .req     (~empty_v),
    .adv     (rd_en),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .gnt_any (gnt_any)
  );

  assign pop_v = gnt & {NCH{rd_en}};

  logic           rv_q, rv_d;
  logic [CHW-1:0] rch_q, rch_d;
  logic [DW-1:0]  rdt_q, rdt_d;

  always_comb begin
    rv_d  = rd_en && gnt_any;
    rch_d = rv_d ? gnt_idx       : rch_q;
    rdt_d = rv_d ? rdat[gnt_idx] : rdt_q;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rv_q  <= 1'b0;
      rch_q <= '0;
      rdt_q <= '0;
    end else begin
      rv_q  <= rv_d;
      rch_q <= rch_d;
      rdt_q <= rdt_d;
    end
  end

  assign rd_valid = rv_q;
  assign rd_chan  = rch_q;
  assign rd_data  = rdt_q;

  // R4: a full buffer raises the halt flag on the next write edge
  a_r4_halt_on_full: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    any_full |=> halt_q);
  // R5: the flag only drops after every buffer was at the low level
  a_r5_release_low: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $fell(halt_q) |-> $past(all_low));
  // R6: no storage while acquisition is not armed
  a_r6_idle_no_store: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !run_q |-> (push_v == '0));
  // R7: output word only after an enabled read cycle
  a_r7_valid_needs_en: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_valid |-> $past(rd_en));
endmodule

// File: tb/sim_evbuf_section.sv
module sim_evbuf_section;
  localparam int DW = 12;
  localparam int AW = 4;
  localparam int NC = 8;

  logic            wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic            wr_acq_en = 1'b0, rd_en = 1'b0;
  logic [NC-1:0]   wr_valid = '0;
  logic [NC*DW-1:0] wr_data = '0;
  logic            wr_halt, rd_valid;
  logic [2:0]      rd_chan;
  logic [DW-1:0]   rd_data;

  int checks = 0, errors = 0;
  int cap_n = 0;
  logic [2:0]    cap_ch [64];
  logic [DW-1:0] cap_dt [64];

  always #2  rd_clk = ~rd_clk;
  always #32 wr_clk = ~wr_clk;

  evbuf_section #(.DW(DW), .AW(AW)) u0 (
    .wr_clk(wr_clk), .rst_n(rst_n), .wr_acq_en(wr_acq_en), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_halt(wr_halt), .rd_clk(rd_clk), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_chan(rd_chan), .rd_data(rd_data)
  );

  always @(negedge rd_clk) begin
    if (rd_valid && cap_n < 64) begin
      cap_ch[cap_n] = rd_chan;
      cap_dt[cap_n] = rd_data;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_n(input logic [NC-1:0] mask, input int n, input int seq0);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_valid = mask;
      for (int c = 0; c < NC; c++) wr_data[c*DW +: DW] = DW'(c*256 + seq0 + i);
    end
    @(negedge wr_clk);
    wr_valid = '0;
  endtask

  task automatic pop_n(input int n);
    cap_n = 0;
    @(negedge rd_clk);
    rd_en = 1'b1;
    repeat (n) @(negedge rd_clk);
    rd_en = 1'b0;
    repeat (4) @(negedge rd_clk);
  endtask

  task automatic wait_wr(input int n);
    repeat (n) @(negedge wr_clk);
  endtask

  task automatic t_reset;
    chk(wr_halt == 1'b0, "R1 halt after reset", wr_halt, 0);
    chk(rd_valid == 1'b0, "R1 valid after reset", rd_valid, 0);
    pop_n(4);
    chk(cap_n == 0, "R1 empty buffers give no words", cap_n, 0);
  endtask

  task automatic t_level_at_reset;
    wr_n(8'h01, 2, 0);
    wait_wr(2);
    pop_n(6);
    chk(cap_n == 0, "R6 high level at reset does not arm", cap_n, 0);
  endtask

  task automatic t_round_robin;
    wr_acq_en = 1'b0; wait_wr(4);
    wr_acq_en = 1'b1; wait_wr(4);
    wr_n(8'b0010_0101, 2, 0);
    wait_wr(1);
    pop_n(10);
    chk(cap_n == 6, "R7 one word per enabled non-empty cycle", cap_n, 6);
    for (int i = 0; i < 6; i++) begin
      int ech, eseq;
      ech  = (i % 3 == 0) ? 0 : ((i % 3 == 1) ? 2 : 5);
      eseq = i / 3;
      chk(cap_ch[i] == 3'(ech), "R8 R9 rotating channel order", cap_ch[i], ech);
      chk(cap_dt[i] == DW'(ech*256 + eseq), "R2 data intact", cap_dt[i], ech*256 + eseq);
    end
  endtask

  task automatic t_skip;
    wr_n(8'h42, 1, 0);
    wr_n(8'h40, 2, 1);
    wait_wr(1);
    pop_n(8);
    chk(cap_n == 4, "R7 word count", cap_n, 4);
    chk(cap_ch[0] == 3'd6 && cap_dt[0] == DW'(6*256), "R8 continues after last served", cap_dt[0], 6*256);
    chk(cap_ch[1] == 3'd1 && cap_dt[1] == DW'(256), "R8 wraps and skips empties", cap_dt[1], 256);
    chk(cap_ch[2] == 3'd6 && cap_dt[2] == DW'(6*256+1), "R2 order in channel", cap_dt[2], 6*256+1);
    chk(cap_ch[3] == 3'd6 && cap_dt[3] == DW'(6*256+2), "R2 order in channel", cap_dt[3], 6*256+2);
  endtask

  task automatic t_disarm;
    wr_acq_en = 1'b0; wait_wr(4);
    wr_n(8'h08, 2, 0);
    wait_wr(1);
    pop_n(6);
    chk(cap_n == 0, "R6 low enable drops writes", cap_n, 0);
    wr_acq_en = 1'b1; wait_wr(4);
  endtask

  task automatic t_full_hyst;
    wr_n(8'h02, 16, 0);
    wait_wr(3);
    chk(wr_halt == 1'b1, "R4 halt raised at full", wr_halt, 1);
    wr_n(8'h0A, 4, 16);
    wait_wr(1);
    pop_n(11);
    chk(cap_n == 11, "R3 first drain count", cap_n, 11);
    chk(cap_dt[10] == DW'(256 + 10), "R2 drained order", cap_dt[10], 256 + 10);
    wait_wr(6);
    chk(wr_halt == 1'b1, "R5 halt held above low level", wr_halt, 1);
    pop_n(1);
    chk(cap_dt[0] == DW'(256 + 11), "R2 next word", cap_dt[0], 256 + 11);
    wait_wr(6);
    chk(wr_halt == 1'b0, "R5 halt released at low level", wr_halt, 0);
    wr_n(8'h08, 1, 40);
    wait_wr(1);
    pop_n(12);
    chk(cap_n == 5, "R4 words sent during halt were dropped", cap_n, 5);
    chk(cap_ch[0] == 3'd3 && cap_dt[0] == DW'(3*256 + 40), "R5 writes resume", cap_dt[0], 3*256 + 40);
    chk(cap_ch[4] == 3'd1 && cap_dt[4] == DW'(256 + 15), "R4 last stored word", cap_dt[4], 256 + 15);
  endtask

  initial begin
    wr_acq_en = 1'b1;
    #100 rst_n = 1'b1;
    wait_wr(4);
    t_reset;
    t_level_at_reset;
    t_round_robin;
    t_skip;
    t_disarm;
    t_full_hyst;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule